// File: doc/BRIEF.md
# Clocked Read Responder with Programmable Wait States

This block is the memory end of a single-clock read bus. A bus master presents an address together with an address-qualifier line, then raises a read request. When the responder sees both lines high at a rising clock edge while it is idle, it accepts the read. It then returns one word from its internal register array.

The delay before the word appears is set per access by a wait-count input. A count of zero makes the responder behave as a fast memory: the word appears one cycle after acceptance, and the stall line never rises. A non-zero count makes it a slow memory. It raises the stall line for that many clock periods, so the master cannot take an unfinished word. It then drops the stall line in the same cycle that it puts the word on the bus. A master working on the falling edge can therefore sample on the next falling edge.

The word stays on the bus for as long as the request is held. After the master withdraws the request, the word stays for one more clock period, and then the bus returns to zero. A simple load port fills the array.

Top module: `rd_responder`

## Requirements
- R1: With a wait count N from 1 to 15 sampled at the accepting edge, `bus_wait` is high for exactly N clock periods, starting in the cycle after that edge.
- R2: With a wait count of 0 at the accepting edge, `bus_wait` stays low for the whole access, and `data_valid` rises in the cycle after the accepting edge.
- R3: At the end of a slow access, `bus_wait` falls on the same edge at which `data_valid` rises. `data_out` then carries the array word at the address sampled on the accepting edge.
- R4: While `rd_req` stays high after the word is presented, `data_valid` stays high and `data_out` stays unchanged.
- R5: When `rd_req` is first seen low after the word is presented, `data_valid` and the word remain for exactly one more clock period. After that, both go to zero, and a new request is accepted no earlier than the following edge.
- R6: An access starts only when `rd_req` and `addr_valid` are both high at an edge while the responder is idle. Either line alone leaves `bus_wait` and `data_valid` low.
- R7: If `rd_req` is seen low during the stall period, `bus_wait` falls at that edge, and no word is presented for that access.
- R8: Whenever `data_valid` is low, `data_out` is zero.
- R9: While reset is asserted (active low), `bus_wait`, `data_valid` and `data_out` are all zero, and the responder is idle once reset is released.
- R10: A high `ld_en` at a rising edge writes `ld_data` into the array word indexed by `ld_addr`. Later reads of that address return the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read request from the master |
| addr_valid | input | 1 | Address on `addr` is valid |
| addr | input | ADDR_W (8) | Word address of the read |
| wait_cycles | input | WAIT_W (4) | Stall periods for this access; 0 means fast |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | ADDR_W (8) | Array load address |
| ld_data | input | DATA_W (16) | Array load word |
| bus_wait | output | 1 | Stall line; high while the word is not ready |
| data_valid | output | 1 | High while a word is driven on `data_out` |
| data_out | output | DATA_W (16) | Read data bus; zero when not driven |

## Verification
Reads are run with wait counts of 0, 1, 3 and 15. This separates the fast path from the stall counter and exposes an off-by-one at either end of the count range. Requests are held for different lengths, and some are re-raised in the cycle after a drop, so that the one-period data hold can be told apart from an early release or a lingering word. Other patterns cover an address-qualifier that is high without a request, a request without the qualifier, a request withdrawn during the stall, a wait count that changes during a stall, and a reset in the middle of an access. Each of these checks that only the edge that accepts the read matters.

// File: rtl/rd_responder.sv
module rd_responder #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic              bus_wait,
  output logic              data_valid,
  output logic [DATA_W-1:0] data_out
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_DRIVE, S_HOLD} st_t;

  st_t               state;
  logic [ADDR_W-1:0] idx_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [DATA_W-1:0] mem [DEPTH];

  wire accept = (state == S_IDLE) && rd_req && addr_valid;
  wire fast   = (wait_cycles == '0);

  always_ff @(posedge clk)
    if (ld_en) mem[ld_addr] <= ld_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      idx_q      <= '0;
      cnt_q      <= '0;
      bus_wait   <= 1'b0;
      data_valid <= 1'b0;
      data_out   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          idx_q <= addr;
          if (fast) begin
            data_valid <= 1'b1;
            data_out   <= mem[addr];
            state      <= S_DRIVE;
          end else begin
            bus_wait <= 1'b1;
            cnt_q    <= wait_cycles - 1'b1;
            state    <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (!rd_req) begin
            bus_wait <= 1'b0;
            state    <= S_IDLE;
          end else if (cnt_q == '0) begin
            bus_wait   <= 1'b0;
            data_valid <= 1'b1;
            data_out   <= mem[idx_q];
            state      <= S_DRIVE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_DRIVE: if (!rd_req) state <= S_HOLD;
        S_HOLD: begin
          data_valid <= 1'b0;
          data_out   <= '0;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SLOW_RAISES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !fast |=> bus_wait); // R1
  AST_FAST_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fast |=> !bus_wait && data_valid); // R2
  AST_WAIT_DATA_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wait && data_valid)); // R3
  AST_WAIT_DROP_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wait) && $past(rd_req) |-> data_valid); // R3
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid && rd_req && state == S_DRIVE |=> data_valid && $stable(data_out)); // R4
  AST_HOLD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_DRIVE && !rd_req |=> data_valid && $stable(data_out)); // R5
  AST_HOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_HOLD |=> !data_valid); // R5
  AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && !(rd_req && addr_valid) |=> !bus_wait && !data_valid); // R6
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait && !rd_req |=> !bus_wait && !data_valid); // R7
  AST_ZERO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> data_out == '0); // R8
endmodule

// File: tb/rd_responder_tb.sv
module rd_responder_tb;
  logic        clk = 0, rst_n = 0, rd_req = 0, addr_valid = 0, ld_en = 0;
  logic [7:0]  addr = 0, ld_addr = 0;
  logic [3:0]  wait_cycles = 0;
  logic [15:0] ld_data = 0;
  logic        bus_wait, data_valid;
  logic [15:0] data_out;

  rd_responder u_dut (.clk(clk), .rst_n(rst_n), .rd_req(rd_req), .addr_valid(addr_valid),
    .addr(addr), .wait_cycles(wait_cycles), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .bus_wait(bus_wait), .data_valid(data_valid), .data_out(data_out));

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string phase = "R9";

  int m_st, m_cnt, m_idx;
  bit m_wait, m_dv;
  int m_data;
  int mem_m [256];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_wait = 0; m_dv = 0; m_data = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (rd_req && addr_valid) begin
             m_idx = addr;
             if (wait_cycles == 0) begin m_dv = 1; m_data = mem_m[addr]; m_st = 2; end
             else begin m_wait = 1; m_cnt = wait_cycles; m_st = 1; end
           end
        1: if (!rd_req) begin m_wait = 0; m_st = 0; end
           else begin
             m_cnt--;
             if (m_cnt == 0) begin m_wait = 0; m_dv = 1; m_data = mem_m[m_idx]; m_st = 2; end
           end
        2: if (!rd_req) m_st = 3;
        default: begin m_dv = 0; m_data = 0; m_st = 0; end
      endcase
      if (ld_en) mem_m[ld_addr] = ld_data;
    end
  end

  function automatic string st_tag(int s);
    case (s)
      0: return "R6";
      1: return "R1";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check({phase, "/", st_tag(m_st)}, bus_wait, m_wait, "bus_wait");
    check({phase, "/", st_tag(m_st)}, data_valid, m_dv, "data_valid");
    check({phase, "/R8"}, data_out, m_data, "data_out");
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(int a, int n, int hold);
    addr = a[7:0]; addr_valid = 1; wait_cycles = n[3:0]; rd_req = 1;
    tick(n + 1 + hold);
    rd_req = 0; addr_valid = 0;
    tick(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    tick(2);
    phase = "R9";
    check("R9", bus_wait, 0, "reset bus_wait");
    check("R9", data_valid, 0, "reset data_valid");
    check("R9", data_out, 0, "reset data_out");
    rst_n = 1;
    phase = "R10";
    for (int i = 0; i < 256; i++) begin
      ld_en = 1; ld_addr = i[7:0]; ld_data = 16'(i * 16'h9e37 + 16'h1234);
      tick();
    end
    ld_en = 0; tick();
    phase = "R2"; rd(5, 0, 3); rd(255, 0, 0);
    phase = "R1"; rd(17, 1, 2); rd(200, 3, 1); rd(0, 15, 2);
    phase = "R3"; rd(99, 2, 0);
    phase = "R6";
    addr = 8'd40; addr_valid = 1; tick(4); addr_valid = 0;
    rd_req = 1; tick(4); rd_req = 0; tick(2);
    addr_valid = 1; wait_cycles = 4'd2; tick(3); rd_req = 1; tick(6);
    rd_req = 0; addr_valid = 0; tick(3);
    phase = "R7";
    addr = 8'd77; addr_valid = 1; wait_cycles = 4'd6; rd_req = 1; tick(3);
    rd_req = 0; addr_valid = 0; tick(4);
    phase = "R1";
    addr = 8'd12; addr_valid = 1; wait_cycles = 4'd4; rd_req = 1; tick(1);
    wait_cycles = 4'd1; tick(7); rd_req = 0; addr_valid = 0; tick(3);
    phase = "R5";
    addr = 8'd3; addr_valid = 1; wait_cycles = 0; rd_req = 1; tick(3);
    rd_req = 0; tick(1); rd_req = 1; addr = 8'd4; tick(5);
    rd_req = 0; addr_valid = 0; tick(3);
    phase = "R10";
    ld_en = 1; ld_addr = 8'd130; ld_data = 16'hbeef; tick(); ld_en = 0; tick();
    rd(130, 2, 1);
    phase = "R9";
    addr = 8'd9; addr_valid = 1; wait_cycles = 4'd5; rd_req = 1; tick(2);
    rst_n = 0; #1;
    check("R9", bus_wait, 0, "mid reset bus_wait");
    check("R9", data_valid, 0, "mid reset data_valid");
    check("R9", data_out, 0, "mid reset data_out");
    rd_req = 0; addr_valid = 0; tick(2); rst_n = 1; tick(2);
    phase = "R2"; rd(9, 0, 1);
    finish_run();
  end
endmodule